// File: doc/BRIEF.md
# Dot-Matrix Row Scan Sequencer

This block paces the multiplexed refresh of a dot-matrix liquid-crystal panel. It steps a single active row through the panel one time slot at a time. For each slot it reads one 40-bit row of display memory, shapes that row according to the current display status, and presents the result on the column outputs together with a one-hot row select. The display memory holds 32 rows, grouped into four banks of eight. A start-bank setting chooses which bank appears at the top of the panel, and the bank index wraps modulo four, so text can be scrolled without moving any memory contents.

The multiplex rate fixes how many rows are scanned per frame: 8, 16, 24 or 32. The 40 outputs are shared between rows and columns in groups of eight. With a rate of 8·(M+1) rows, output groups 0..M carry row drive and the remaining groups carry column data. The column bit for output k is always taken from memory column k. Rate, status and start bank are sampled only at a frame boundary. A frame pulse marks the first slot of each frame. The number of clock cycles per slot can be programmed.

Top module: `dmx_scan_seq`

## Requirements
- R1: The rate code M on `mux_rate_i` (00 = 8 rows, 01 = 16, 10 = 24, 11 = 32) makes a frame cover rows 0 to 8·(M+1)−1. The frame period is therefore 8·(M+1)·(L+1) clock cycles, where L is the value of `slot_len_i`.
- R2: Bits k < 8·(M+1) of `col_data_o` are 0, because those outputs drive rows. Bits 0–7 are always 0. Bits 32–39 always carry column data.
- R3: `row_sel_o` is one-hot after start-up. It begins a frame at bit 0, steps up by one bit per slot, and returns to bit 0 after the last row of the rate.
- R4: Each row slot lasts `slot_len_i` + 1 clock cycles.
- R5: Scan row r reads memory row (B·8 + r) mod 32, where B is the start bank. Bit k of `col_data_o` comes from memory column k. Outputs present the row that was addressed one clock earlier.
- R6: Display status code 00 forces every column bit to 0 (blank). Code 01 forces every column bit to 1 (all on). Code 10 passes memory data unchanged. Code 11 inverts memory data. The row-group masking of R2 is applied after this shaping.
- R7: Changes to rate, status or start bank take effect only in the frame that follows the current one. The frame in progress keeps its settings.
- R8: `frame_o` is high for exactly one cycle per frame, in the cycle in which `row_sel_o` first selects row 0 of that frame.
- R9: While reset is held, all outputs are 0. The first frame after reset is blank, scans 8 rows and uses start bank 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mux_rate_i | input | 2 | Multiplex rate code M |
| disp_mode_i | input | 2 | Display status code |
| start_bank_i | input | 2 | Bank shown at the top of the panel |
| slot_len_i | input | 8 | Cycles per row slot minus one |
| ram_addr_o | output | 5 | Display memory row address (asynchronous read) |
| ram_data_i | input | 40 | Display memory row data for `ram_addr_o` |
| row_sel_o | output | 32 | One-hot row select |
| col_data_o | output | 40 | Shaped column data, with row-group outputs at 0 |
| frame_o | output | 1 | One-cycle frame-start pulse |

## Verification
Properties are checked on every cycle:
- the row select is one-hot or zero, and the active row stays within the rate's range;
- the row advances by exactly one at the end of each slot;
- the latched settings change only at a frame wrap;
- the frame pulse coincides with row 0 and lasts a single cycle;
- the low row group never carries data.

Other behaviour can only be shown by the bench's scenarios: the modulo-four bank rotation of the memory address, the four status shapings, the exact frame and slot periods, and the blank first frame after reset. The bench covers these with a cycle model, with frame-period measurements, and with mid-frame setting changes.

// File: rtl/dmx_scan_pkg.sv
package dmx_scan_pkg;

  typedef enum logic [1:0] {
    DISP_BLANK  = 2'b00,
    DISP_ALLON  = 2'b01,
    DISP_NORMAL = 2'b10,
    DISP_INVERT = 2'b11
  } disp_mode_e;

endpackage

// File: rtl/dmx_scan_timer.sv
module dmx_scan_timer
  import dmx_scan_pkg::*;
#(
  parameter int BANK_ROWS = 8,
  parameter int BANKS     = 4,
  parameter int SLOT_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SLOT_W-1:0]                slot_len_i,
  input  logic [$clog2(BANKS)-1:0]         rate_i,
  input  disp_mode_e                       mode_i,
  input  logic [$clog2(BANKS)-1:0]         bank_i,
  output logic [$clog2(BANK_ROWS*BANKS)-1:0] row_o,
  output logic                             slot_zero_o,
  output logic [$clog2(BANKS)-1:0]         rate_o,
  output disp_mode_e                       mode_o,
  output logic [$clog2(BANKS)-1:0]         bank_o
);

  localparam int ROWS   = BANK_ROWS * BANKS;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int BANK_W = $clog2(BANKS);
  localparam int OFF_W  = $clog2(BANK_ROWS);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [BANK_W-1:0] rate_q, rate_d, bank_q, bank_d;
  disp_mode_e        mode_q, mode_d;
  logic [ROW_W-1:0]  last_row;
  logic              slot_end, wrap;

  // last row of the frame is rate*BANK_ROWS + BANK_ROWS-1
  assign last_row = {rate_q, {OFF_W{1'b1}}};
  assign slot_end = (slot_q >= slot_len_i);
  assign wrap     = slot_end && (row_q == last_row);

  always_comb begin
    slot_d = slot_q;
    row_d  = row_q;
    rate_d = rate_q;
    mode_d = mode_q;
    bank_d = bank_q;
    if (slot_end) begin
      slot_d = '0;
      if (wrap) begin
        row_d  = '0;
        rate_d = rate_i;
        mode_d = mode_i;
        bank_d = bank_i;
      end else begin
        row_d = row_q + 1'b1;
      end
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      row_q  <= '0;
      rate_q <= '0;
      mode_q <= DISP_BLANK;
      bank_q <= '0;
    end else begin
      slot_q <= slot_d;
      row_q  <= row_d;
      rate_q <= rate_d;
      mode_q <= mode_d;
      bank_q <= bank_d;
    end
  end

  assign row_o       = row_q;
  assign slot_zero_o = (slot_q == '0);
  assign rate_o      = rate_q;
  assign mode_o      = mode_q;
  assign bank_o      = bank_q;

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= last_row); // R1

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !wrap) |=> (row_q == ROW_W'($past(row_q) + 1'b1))); // R3

  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable({rate_q, mode_q, bank_q})); // R7

endmodule

// File: rtl/dmx_row_map.sv
module dmx_row_map #(
  parameter int BANK_ROWS = 8,
  parameter int BANKS     = 4
) (
  input  logic [$clog2(BANK_ROWS*BANKS)-1:0] row_i,
  input  logic [$clog2(BANKS)-1:0]           bank_i,
  output logic [$clog2(BANK_ROWS*BANKS)-1:0] addr_o
);

  localparam int ROW_W  = $clog2(BANK_ROWS * BANKS);
  localparam int BANK_W = $clog2(BANKS);
  localparam int OFF_W  = $clog2(BANK_ROWS);

  logic [BANK_W-1:0] bank_sum;

  // bank index wraps modulo BANKS through the truncated add
  assign bank_sum = bank_i + row_i[ROW_W-1:OFF_W];
  assign addr_o   = {bank_sum, row_i[OFF_W-1:0]};

endmodule

// File: rtl/dmx_pixel_shaper.sv
module dmx_pixel_shaper
  import dmx_scan_pkg::*;
#(
  parameter int COLS      = 40,
  parameter int BANK_ROWS = 8,
  parameter int BANKS     = 4
) (
  input  logic [COLS-1:0]          data_i,
  input  disp_mode_e               mode_i,
  input  logic [$clog2(BANKS)-1:0] rate_i,
  output logic [COLS-1:0]          col_o
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int GROUPS = COLS / BANK_ROWS;

  logic [COLS-1:0]   shaped;
  logic [GROUPS-1:0] grp_row;

  always_comb begin
    case (mode_i)
      DISP_BLANK:  shaped = '0;
      DISP_ALLON:  shaped = '1;
      DISP_NORMAL: shaped = data_i;
      default:     shaped = ~data_i;
    endcase
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    if (g < BANKS) begin : g_shared
      localparam logic [BANK_W-1:0] GIDX = BANK_W'(g);
      assign grp_row[g] = (GIDX <= rate_i);
    end else begin : g_fixed_col
      assign grp_row[g] = 1'b0;
    end
    assign col_o[g*BANK_ROWS +: BANK_ROWS] =
      grp_row[g] ? '0 : shaped[g*BANK_ROWS +: BANK_ROWS];
  end

endmodule

// File: rtl/dmx_scan_seq.sv
module dmx_scan_seq
  import dmx_scan_pkg::*;
#(
  parameter int COLS      = 40,
  parameter int BANK_ROWS = 8,
  parameter int BANKS     = 4,
  parameter int SLOT_W    = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(BANKS)-1:0]           mux_rate_i,
  input  logic [1:0]                         disp_mode_i,
  input  logic [$clog2(BANKS)-1:0]           start_bank_i,
  input  logic [SLOT_W-1:0]                  slot_len_i,
  output logic [$clog2(BANK_ROWS*BANKS)-1:0] ram_addr_o,
  input  logic [COLS-1:0]                    ram_data_i,
  output logic [BANK_ROWS*BANKS-1:0]         row_sel_o,
  output logic [COLS-1:0]                    col_data_o,
  output logic                               frame_o
);

  localparam int ROWS   = BANK_ROWS * BANKS;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int BANK_W = $clog2(BANKS);

  logic              rst_meta, rst_sync;
  logic [ROW_W-1:0]  row;
  logic              slot_zero;
  logic [BANK_W-1:0] act_rate, act_bank;
  disp_mode_e        act_mode;
  logic [COLS-1:0]   col_shaped;

  logic [ROWS-1:0]   row_sel_q, row_sel_d;
  logic [COLS-1:0]   col_q, col_d;
  logic              frame_q, frame_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dmx_scan_timer #(
    .BANK_ROWS(BANK_ROWS), .BANKS(BANKS), .SLOT_W(SLOT_W)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_sync),
    .slot_len_i (slot_len_i),
    .rate_i     (mux_rate_i),
    .mode_i     (disp_mode_e'(disp_mode_i)),
    .bank_i     (start_bank_i),
    .row_o      (row),
    .slot_zero_o(slot_zero),
    .rate_o     (act_rate),
    .mode_o     (act_mode),
    .bank_o     (act_bank)
  );

  dmx_row_map #(
    .BANK_ROWS(BANK_ROWS), .BANKS(BANKS)
  ) map_i (
    .row_i (row),
    .bank_i(act_bank),
    .addr_o(ram_addr_o)
  );

  dmx_pixel_shaper #(
    .COLS(COLS), .BANK_ROWS(BANK_ROWS), .BANKS(BANKS)
  ) shaper_i (
    .data_i(ram_data_i),
    .mode_i(act_mode),
    .rate_i(act_rate),
    .col_o (col_shaped)
  );

  always_comb begin
    row_sel_d = ROWS'(1) << row;
    col_d     = col_shaped;
    frame_d   = (row == '0) && slot_zero;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      row_sel_q <= '0;
      col_q     <= '0;
      frame_q   <= 1'b0;
    end else begin
      row_sel_q <= row_sel_d;
      col_q     <= col_d;
      frame_q   <= frame_d;
    end
  end

  assign row_sel_o  = row_sel_q;
  assign col_data_o = col_q;
  assign frame_o    = frame_q;

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(row_sel_o)); // R3

  AST_FRAME_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_sync)
    frame_o |-> row_sel_o[0]); // R8

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync)
    frame_o |=> !frame_o); // R8

  AST_LOW_GROUP_DARK: assert property (@(posedge clk) disable iff (!rst_sync)
    col_data_o[BANK_ROWS-1:0] == '0); // R2

endmodule

// File: tb/dmx_scan_seq_tb.sv
`timescale 1ns/1ps
module dmx_scan_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_in, mode_in, bank_in;
  logic [7:0]  slot_in;
  logic [4:0]  ram_addr;
  logic [39:0] ram_data;
  logic [31:0] row_sel;
  logic [39:0] col_data;
  logic        frame;

  logic [39:0] mem [32];

  int checks = 0;
  int failures = 0;
  bit run_model = 0;
  bit done = 0;

  int m_slot, m_row, m_rate, m_mode, m_bank;
  int cyc_since = 0;
  int last_period = 0;
  int frame_count = 0;

  always #2 clk = ~clk;

  assign ram_data = mem[ram_addr];

  dmx_scan_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_rate_i  (rate_in),
    .disp_mode_i (mode_in),
    .start_bank_i(bank_in),
    .slot_len_i  (slot_in),
    .ram_addr_o  (ram_addr),
    .ram_data_i  (ram_data),
    .row_sel_o   (row_sel),
    .col_data_o  (col_data),
    .frame_o     (frame)
  );

  function automatic logic [39:0] col_mask(int rate);
    logic [39:0] m;
    for (int k = 0; k < 40; k++) m[k] = (k >= 8 * (rate + 1));
    return m;
  endfunction

  function automatic logic [39:0] shape(logic [39:0] d, int mode);
    case (mode)
      0: return '0;
      1: return '1;
      2: return d;
      default: return ~d;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle model: evaluated at the falling edge, before stimulus moves
  always @(negedge clk) begin
    if (run_model) begin
      logic [39:0] d;
      d = mem[(m_bank * 8 + m_row) % 32];
      chk("R3 row_sel", 64'(row_sel), 64'(32'd1 << m_row));
      chk("R8 frame", 64'(frame), 64'(m_row == 0 && m_slot == 0));
      chk("R5/R6 col_data", 64'(col_data), 64'(shape(d, m_mode) & col_mask(m_rate)));
      cyc_since++;
      if (frame) begin
        last_period = cyc_since;
        cyc_since = 0;
        frame_count++;
      end
      if (m_slot >= int'(slot_in)) begin
        m_slot = 0;
        if (m_row == 8 * (m_rate + 1) - 1) begin
          m_row  = 0;
          m_rate = int'(rate_in);
          m_mode = int'(mode_in);
          m_bank = int'(bank_in);
        end else m_row++;
      end else m_slot++;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_pulses(int n);
    int c0 = frame_count;
    while (frame_count < c0 + n) step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) mem[i] = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
    rate_in = 2'd3; mode_in = 2'd2; bank_in = 2'd2; slot_in = 8'd3;
    m_slot = 0; m_row = 0; m_rate = 0; m_mode = 0; m_bank = 0;

    // R9: outputs held at zero during reset
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 reset row_sel", 64'(row_sel), 64'd0);
      chk("R9 reset col_data", 64'(col_data), 64'd0);
      chk("R9 reset frame", 64'(frame), 64'd0);
    end
    rst_n = 1'b1;
    step();
    chk("R9 sync release row_sel", 64'(row_sel), 64'd0);
    step();
    chk("R9 sync release col_data", 64'(col_data), 64'd0);
    run_model = 1;

    // R9: first frame is blank even though normal video is requested
    for (int i = 0; i < 30; i++) begin
      step();
      chk("R9 first frame blank", 64'(col_data), 64'd0);
    end

    // R1: frame period per rate
    rate_in = 2'd3; slot_in = 8'd3;
    wait_pulses(2);
    chk("R1 period 1:32", 64'(last_period), 64'(32 * 4));
    rate_in = 2'd0;
    wait_pulses(2);
    chk("R1 period 1:8", 64'(last_period), 64'(8 * 4));
    rate_in = 2'd2;
    wait_pulses(2);
    chk("R1 period 1:24", 64'(last_period), 64'(24 * 4));

    // R4: slot length scaling
    rate_in = 2'd1; slot_in = 8'd0;
    wait_pulses(2);
    chk("R4 period slot 1", 64'(last_period), 64'(16 * 1));
    slot_in = 8'd5;
    wait_pulses(2);
    chk("R4 period slot 6", 64'(last_period), 64'(16 * 6));

    // R2: row groups dark, column groups lit with all-on status
    mode_in = 2'd1; rate_in = 2'd1; slot_in = 8'd2;
    wait_pulses(1);
    step();
    chk("R2 all-on mask 1:16", 64'(col_data), 64'(40'hFF_FFFF_0000));
    rate_in = 2'd3;
    wait_pulses(1);
    step();
    chk("R2 all-on mask 1:32", 64'(col_data), 64'(40'hFF_0000_0000));

    // R7: a mid-frame change waits for the next frame
    repeat (3) step();
    mode_in = 2'd0;
    step();
    chk("R7 hold status in frame", 64'(col_data), 64'(40'hFF_0000_0000));
    step();
    chk("R7 hold status in frame", 64'(col_data), 64'(40'hFF_0000_0000));
    wait_pulses(1);
    step();
    chk("R7 new status next frame", 64'(col_data), 64'd0);

    // R5/R6: random settings and memory traffic against the model
    for (int it = 0; it < 60; it++) begin
      rate_in = 2'($urandom_range(0, 3));
      mode_in = 2'($urandom_range(0, 3));
      bank_in = 2'($urandom_range(0, 3));
      slot_in = 8'($urandom_range(0, 3));
      if (it % 10 == 0) mode_in = 2'd3;
      for (int c = 0; c < int'($urandom_range(1, 80)); c++) begin
        if ($urandom_range(0, 3) == 0)
          mem[$urandom_range(0, 31)] = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
        step();
      end
    end

    // R5: bank rotation wraps past the last bank
    bank_in = 2'd3; mode_in = 2'd2; rate_in = 2'd3; slot_in = 8'd1;
    wait_pulses(2);
    repeat (20) step();

    done = 1;
    summary();
  end

endmodule